// File: doc/BRIEF.md
# Pipelined SRAM Slave with Ready Countdown

This block connects a simple on-chip master to an external asynchronous SRAM over a point-to-point link. The master presents an address, write data and a read or write strobe for a single clock cycle. It receives no acknowledge. The slave captures the command into its own registers on that edge. From registers, it then drives the SRAM address, write data, write-data enable and the active-low chip-select, output-enable and write-enable pins. This keeps every SRAM-facing signal suitable for placement in I/O-pad flops.

Instead of an ack or wait states, the slave reports a busy count. The count gives the number of cycles left until the current read result is available or the current write has finished. It also drives a constant overlap level, which tells the master how early it may issue the next command. At level 0 the master waits for a count of zero. At level 1 it may issue a command when the count reads one. That is the cycle in which the previous read is sampled, so the old result and the new access share an edge.

The last read word stays on the read-data output until another read completes. The number of SRAM wait states is a parameter.

Top module: `sram_cdn_slave`

## Requirements
- R1: A command is taken from the bus inputs on one clock edge and is never acknowledged. From the next cycle, `mem_addr` shows the captured address. During a write, `mem_wdata` shows the captured data. Both are held for the whole access.
- R2: When a command is accepted, `busy_cnt` loads WAIT_ST+1. While it is nonzero and no command is accepted, it falls by one per cycle, and it rests at zero.
- R3: A command is accepted only when `busy_cnt` is at or below the overlap level (level 0: only at 0; level 1: at 0 or 1). A command offered at a higher count is ignored: the count keeps falling and the SRAM is not touched.
- R4: A cycle with both `bus_rd` and `bus_wr` high is not a command. It is ignored.
- R5: A read holds `mem_cs_n` and `mem_oe_n` low for WAIT_ST+1 cycles, with `mem_we_n` high. `mem_rdata` is sampled on the edge where the count goes from 1 to 0, and the word appears on `bus_rdata` in the cycle the count reads 0.
- R6: A write holds `mem_cs_n` low and `mem_wdata_en` high for WAIT_ST+1 cycles. `mem_we_n` is low for the first WAIT_ST of those cycles and high in the last one, and `mem_oe_n` stays high.
- R7: `bus_rdata` changes only when a read completes. It stays stable through idle cycles and writes.
- R8: At overlap level 1, a command issued when the count reads 1 is accepted. On that edge, the running read's data is captured and the new access starts, with the count reloaded to WAIT_ST+1.
- R9: `overlap_lvl` is constant and equals the PIPE_LVL parameter (0 or 1).
- R10: While reset is high: `busy_cnt` is 0, all three SRAM controls are high, `mem_wdata_en` is 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Command address, valid with a strobe |
| bus_wdata | input | DATA_W | Write data, valid with the write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| busy_cnt | output | CNT_W | Cycles left until the current access is done |
| bus_rdata | output | DATA_W | Last completed read word |
| overlap_lvl | output | 2 | Static overlap level |
| mem_addr | output | ADDR_W | Registered SRAM address |
| mem_wdata | output | DATA_W | Registered SRAM write data |
| mem_wdata_en | output | 1 | Drive enable for the SRAM data pins |
| mem_rdata | input | DATA_W | Data returned by the SRAM |
| mem_cs_n | output | 1 | Registered chip-select, active low |
| mem_oe_n | output | 1 | Registered output-enable, active low |
| mem_we_n | output | 1 | Registered write-enable, active low |

## Verification
The completion of a read and the start of the next access can fall on the same edge. That edge is where the old word must land in `bus_rdata` while the count reloads and the address changes. The bench provokes this by sweeping reads over the whole address space of a small SRAM model. Each read is issued exactly when the count reads one. In the cycle after each issue, the bench checks that `bus_rdata` holds the word of the previous address, computed arithmetically, and that the count shows WAIT_ST+1. A second instance at level 0 confirms that the same early issue is ignored there.

// File: rtl/sram_cdn_pkg.sv
package sram_cdn_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

    function automatic op_e decode_cmd(logic rd, logic wr);
        if (rd && !wr) return OP_RD;
        if (wr && !rd) return OP_WR;
        return OP_IDLE;
    endfunction

    function automatic pins_t pins_for(op_e op, logic active, logic last);
        pins_t p;
        p.cs_n = !active;
        p.oe_n = !(active && (op == OP_RD));
        p.we_n = !(active && (op == OP_WR) && !last);
        p.drv  = active && (op == OP_WR);
        return p;
    endfunction

endpackage

// File: rtl/sram_cdn_accept.sv
module sram_cdn_accept
    import sram_cdn_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int PIPE_LVL = 1
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             rd,
    input  logic             wr,
    output logic             accept,
    output op_e              op
);
    logic window_open;

    generate
        if (PIPE_LVL == 0) begin : g_no_overlap
            assign window_open = (cnt == '0);
        end else begin : g_overlap_one
            assign window_open = (cnt <= CNT_W'(1));
        end
    endgenerate

    assign op     = decode_cmd(rd, wr);
    assign accept = window_open && (op != OP_IDLE);
endmodule

// File: rtl/sram_cdn_seq.sv
module sram_cdn_seq
    import sram_cdn_pkg::*;
#(
    parameter int WAIT_ST = 1,
    parameter int CNT_W   = 2,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  op_e               op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [CNT_W-1:0]  cnt,
    output logic              sample,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output pins_t             pins
);
    localparam int WAIT_EFF = (WAIT_ST < 1) ? 1 : WAIT_ST;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_EFF + 1);

    logic [CNT_W-1:0]  cnt_q, cnt_n;
    op_e               op_q, op_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [DATA_W-1:0] wd_q, wd_n;
    pins_t             pins_q, pins_n;

    always_comb begin
        cnt_n  = cnt_q;
        op_n   = op_q;
        addr_n = addr_q;
        wd_n   = wd_q;
        if (accept) begin
            cnt_n  = LOAD;
            op_n   = op_in;
            addr_n = addr_in;
            wd_n   = wdata_in;
        end else if (cnt_q != '0) begin
            cnt_n = cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) op_n = OP_IDLE;
        end
        pins_n = pins_for(op_n, cnt_n != '0, cnt_n == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            op_q   <= OP_IDLE;
            addr_q <= '0;
            wd_q   <= '0;
            pins_q <= PINS_IDLE;
        end else begin
            cnt_q  <= cnt_n;
            op_q   <= op_n;
            addr_q <= addr_n;
            wd_q   <= wd_n;
            pins_q <= pins_n;
        end
    end

    assign cnt       = cnt_q;
    assign sample    = (cnt_q == CNT_W'(1)) && (op_q == OP_RD);
    assign mem_addr  = addr_q;
    assign mem_wdata = wd_q;
    assign pins      = pins_q;

    // R2: countdown steps by one when idle of new commands
    a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !accept) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: an accepted command reloads the count
    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cnt_q == LOAD));

    // R6: output-enable and write-enable never low together
    a_r6_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
        !(pins_q.oe_n == 1'b0 && pins_q.we_n == 1'b0));

    // R5: no strobe without chip-select
    a_r5_cs_gates: assert property (@(posedge clk) disable iff (rst)
        pins_q.cs_n |-> (pins_q.oe_n && pins_q.we_n && !pins_q.drv));
endmodule

// File: rtl/sram_cdn_hold.sv
module sram_cdn_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (sample) rdata <= mem_rdata;
    end

    // R7: held word moves only on a read completion
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(rdata));
endmodule

// File: rtl/sram_cdn_slave.sv
module sram_cdn_slave
    import sram_cdn_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int WAIT_ST  = 1,
    parameter int PIPE_LVL = 1,
    localparam int CNT_W   = $clog2(((WAIT_ST < 1) ? 1 : WAIT_ST) + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [CNT_W-1:0]  busy_cnt,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        overlap_lvl,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int LVL_EFF = (PIPE_LVL > 0) ? 1 : 0;

    logic  accept;
    op_e   cmd_op;
    logic  sample;
    pins_t pins;

    sram_cdn_accept #(.CNT_W(CNT_W), .PIPE_LVL(LVL_EFF)) u_accept (
        .cnt    (busy_cnt),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .accept (accept),
        .op     (cmd_op)
    );

    sram_cdn_seq #(.WAIT_ST(WAIT_ST), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .op_in     (cmd_op),
        .addr_in   (bus_addr),
        .wdata_in  (bus_wdata),
        .cnt       (busy_cnt),
        .sample    (sample),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pins      (pins)
    );

    sram_cdn_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .sample    (sample),
        .mem_rdata (mem_rdata),
        .rdata     (bus_rdata)
    );

    assign overlap_lvl  = 2'(LVL_EFF);
    assign mem_cs_n     = pins.cs_n;
    assign mem_oe_n     = pins.oe_n;
    assign mem_we_n     = pins.we_n;
    assign mem_wdata_en = pins.drv;

    // R3: a command outside the overlap window does not reload the count
    a_r3_reject: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd ^ bus_wr) && busy_cnt > CNT_W'(LVL_EFF)) |=> (busy_cnt == $past(busy_cnt) - 1'b1));

    // R4: both strobes together start nothing
    a_r4_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr && busy_cnt == '0) |=> (busy_cnt == '0 && mem_cs_n));

    // R10: reset state
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (busy_cnt == '0 && mem_cs_n && mem_oe_n && mem_we_n && !mem_wdata_en && bus_rdata == '0));
endmodule

// File: tb/sram_cdn_slave_bench.sv
`timescale 1ns/1ps
module sram_cdn_slave_bench;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]    busy_cnt;
    logic [DW-1:0] bus_rdata;
    logic [1:0]    overlap_lvl;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_wdata_en, mem_cs_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] mem_rdata;

    sram_cdn_slave #(.ADDR_W(AW), .DATA_W(DW), .WAIT_ST(1), .PIPE_LVL(1)) u_sram_cdn_slave (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .busy_cnt(busy_cnt), .bus_rdata(bus_rdata),
        .overlap_lvl(overlap_lvl), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // level-0 variant
    logic          z_rd = 1'b0, z_wr = 1'b0;
    logic [1:0]    z_cnt, z_lvl;
    logic [DW-1:0] z_rdata, z_wdata;
    logic [AW-1:0] z_addr;
    logic          z_en, z_cs, z_oe, z_we;

    sram_cdn_slave #(.ADDR_W(AW), .DATA_W(DW), .WAIT_ST(1), .PIPE_LVL(0)) u_sram_cdn_slave_l0 (
        .clk(clk), .rst(rst), .bus_addr(8'h11), .bus_wdata(16'h2222),
        .bus_rd(z_rd), .bus_wr(z_wr), .busy_cnt(z_cnt), .bus_rdata(z_rdata),
        .overlap_lvl(z_lvl), .mem_addr(z_addr), .mem_wdata(z_wdata),
        .mem_wdata_en(z_en), .mem_rdata(16'h1234), .mem_cs_n(z_cs),
        .mem_oe_n(z_oe), .mem_we_n(z_we)
    );

    // SRAM model
    logic [DW-1:0] sram [NW];
    always @(posedge clk) if (!mem_cs_n && !mem_we_n && mem_wdata_en) sram[mem_addr] <= mem_wdata;
    assign mem_rdata = (!mem_cs_n && !mem_oe_n) ? sram[mem_addr] : 16'hBAD0;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 40503) ^ 16'h5A5A);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(logic rd, logic wr, logic [AW-1:0] a, logic [DW-1:0] d);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        for (int i = 0; i < NW; i++) sram[i] = 16'h0;
        repeat (3) tick();
        // R10: reset values
        chk("R10 cnt", 32'(busy_cnt), 0);
        chk("R10 ctl", {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en}, 4'b1110);
        chk("R10 rdata", 32'(bus_rdata), 0);
        rst = 1'b0;
        tick();
        // R9
        chk("R9 level1", 32'(overlap_lvl), 1);
        chk("R9 level0", 32'(z_lvl), 0);

        // R1 R2 R6: single write
        drive(1'b0, 1'b1, 8'd5, 16'h1357);
        chk("R2 load", 32'(busy_cnt), 2);
        chk("R1 addr", 32'(mem_addr), 5);
        chk("R1 wdata", 32'(mem_wdata), 32'h1357);
        chk("R6 first", {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en}, 4'b0101);
        tick();
        chk("R2 step", 32'(busy_cnt), 1);
        chk("R6 last", {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en}, 4'b0111);
        chk("R1 hold addr", 32'(mem_addr), 5);
        tick();
        chk("R2 rest", 32'(busy_cnt), 0);
        chk("R6 end", {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en}, 4'b1110);

        // R5 R7: single read
        drive(1'b1, 1'b0, 8'd5, 16'h0);
        chk("R5 first", {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en}, 4'b0010);
        tick();
        chk("R5 second", {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en}, 4'b0010);
        chk("R7 before done", 32'(bus_rdata), 0);
        tick();
        chk("R5 result", 32'(bus_rdata), 32'h1357);
        chk("R5 end", {mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en}, 4'b1110);

        // R7: idle and write keep the word
        repeat (4) tick();
        chk("R7 idle", 32'(bus_rdata), 32'h1357);
        drive(1'b0, 1'b1, 8'd6, 16'h0F0F);
        tick(); tick();
        chk("R7 write", 32'(bus_rdata), 32'h1357);

        // R4: both strobes
        drive(1'b1, 1'b1, 8'd6, 16'hFFFF);
        chk("R4 cnt", 32'(busy_cnt), 0);
        chk("R4 cs", 32'(mem_cs_n), 1);

        // R3: command at count 2 is ignored (protocol violation by intent)
        drive(1'b0, 1'b1, 8'd7, 16'hAAAA);
        $display("note: bench issues a command at count %0d on purpose", busy_cnt);
        drive(1'b0, 1'b1, 8'd7, 16'hBBBB);
        chk("R3 no reload", 32'(busy_cnt), 1);
        chk("R3 addr kept", 32'(mem_wdata), 32'hAAAA);
        tick();
        drive(1'b1, 1'b0, 8'd7, 16'h0);
        tick(); tick();
        chk("R3 memory", 32'(bus_rdata), 32'hAAAA);

        // R8 R2: back-to-back write sweep
        for (int a = 0; a < NW; a++) begin
            drive(1'b0, 1'b1, AW'(a), pat(a));
            chk("R2 sweep load", 32'(busy_cnt), 2);
            tick();
            chk("R2 sweep step", 32'(busy_cnt), 1);
        end
        tick();
        chk("R2 sweep rest", 32'(busy_cnt), 0);

        // R8 R5: overlapped read sweep
        for (int a = 0; a < NW; a++) begin
            drive(1'b1, 1'b0, AW'(a), 16'h0);
            chk("R8 reload", 32'(busy_cnt), 2);
            chk("R1 sweep addr", 32'(mem_addr), 32'(a));
            if (a > 0) chk("R8 prev word", 32'(bus_rdata), 32'(pat(a - 1)));
            tick();
        end
        tick();
        chk("R5 last word", 32'(bus_rdata), 32'(pat(NW - 1)));
        held = bus_rdata;
        tick();
        chk("R7 after sweep", 32'(bus_rdata), 32'(held));

        // R3 at level 0: command at count 1 ignored
        z_rd = 1'b1; tick(); z_rd = 1'b0;
        chk("R2 l0 load", 32'(z_cnt), 2);
        tick();
        chk("R2 l0 step", 32'(z_cnt), 1);
        z_wr = 1'b1; tick(); z_wr = 1'b0;
        chk("R3 l0 ignored", 32'(z_cnt), 0);
        chk("R3 l0 pins", {z_cs, z_we, z_en}, 3'b110);
        chk("R5 l0 word", 32'(z_rdata), 32'h1234);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule